// File: doc/BRIEF.md
# Width-Selective Logical Merge Unit

This unit combines a 64-bit register value with a memory operand by bitwise AND, OR or XOR. It then folds the result back into the register image according to a three-bit operand width code. Byte and halfword operations overwrite only their low field and keep the rest of the lower 32-bit word. Word operations clear the upper 32 bits. Doubleword operations replace all 64 bits.

Alongside the merged value, the unit reports condition flags: zero, negative and positive, plus an overflow flag that is always cleared. The logic path is combinational. A single output register stage captures the merged value and the flags on each cycle where the input is marked valid. The memory operand arrives already zero-extended. Fetching operands and writing the register file back are left to the surrounding pipeline.

Top module: `logic_merge_unit`

## Requirements
- R1: `op_sel` selects the operation: 2'b00 is AND, 2'b01 is OR, and 2'b10 or 2'b11 is XOR. The raw result is `dst_in OP src_in`.
- R2: For `fmt` 4, 5, 6 or 7 (byte), `dst_out[7:0]` is the raw result's bits 7:0, `dst_out[31:8]` equals `dst_in[31:8]`, and `dst_out[63:32]` is zero.
- R3: For `fmt` 1 or 3 (halfword), `dst_out[15:0]` is the raw result's bits 15:0, `dst_out[31:16]` equals `dst_in[31:16]`, and `dst_out[63:32]` is zero.
- R4: For `fmt` 0 (word), `dst_out[31:0]` is the raw result's bits 31:0 and `dst_out[63:32]` is zero.
- R5: For `fmt` 2 (doubleword), `dst_out` is the full 64-bit raw result.
- R6: `flag_zero` is 1 exactly when the whole 64-bit merged value is zero.
- R7: `flag_neg` is the sign bit of the selected width in the merged value: bit 7 for byte, bit 15 for halfword, bit 31 for word and bit 63 for doubleword.
- R8: `flag_pos` is 1 exactly when neither `flag_zero` nor `flag_neg` is set. `flag_ovf` is always 0.
- R9: A request presented with `in_valid` high at a rising clock edge appears on `dst_out` and the flags after that edge, with `out_valid` high for one cycle.
- R10: On an edge where `in_valid` is low, `out_valid` becomes 0 and `dst_out` and all flags keep their previous values.
- R11: While `rst_n` is low, `out_valid`, `dst_out` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | Operation select (AND/OR/XOR) |
| fmt | input | 3 | Operand width code |
| dst_in | input | 64 | Current destination register value |
| src_in | input | 64 | Zero-extended memory operand |
| out_valid | output | 1 | Result registered this cycle |
| dst_out | output | 64 | Merged destination value |
| flag_zero | output | 1 | Merged value is zero |
| flag_neg | output | 1 | Sign bit of selected width set |
| flag_pos | output | 1 | Neither zero nor negative |
| flag_ovf | output | 1 | Overflow, always cleared |

## Verification
Some properties are checked on every cycle:
- the registered upper half is zero after every narrow or word request;
- the zero flag agrees with the registered value;
- exactly one of zero, negative and positive is set after a request;
- `out_valid` follows `in_valid` by one edge;
- the outputs hold while no request is present.

Other behaviour only the bench's scenarios can show against its own model. This covers the choice of operation, which middle bits survive a byte or halfword merge, and the sign bit chosen for each width. The scenarios include a byte result of zero under a nonzero preserved field, and the reserved operation code.

// File: rtl/logic_merge_unit.sv
module logic_merge_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   op_sel,
  input  logic [2:0]   fmt,
  input  logic [W-1:0] dst_in,
  input  logic [W-1:0] src_in,
  output logic         out_valid,
  output logic [W-1:0] dst_out,
  output logic         flag_zero,
  output logic         flag_neg,
  output logic         flag_pos,
  output logic         flag_ovf
);
  localparam int WD = W / 2;
  localparam int HW = W / 4;
  localparam int BY = W / 8;

  logic [W-1:0] raw, merged;
  logic         sgn, zer;

  always_comb begin
    case (op_sel)
      2'b00:   raw = dst_in & src_in;
      2'b01:   raw = dst_in | src_in;
      default: raw = dst_in ^ src_in;
    endcase
  end

  always_comb begin
    case (fmt)
      3'd0: begin
        merged = {{(W-WD){1'b0}}, raw[WD-1:0]};
        sgn    = merged[WD-1];
      end
      3'd2: begin
        merged = raw;
        sgn    = merged[W-1];
      end
      3'd1, 3'd3: begin
        merged = {{(W-WD){1'b0}}, dst_in[WD-1:HW], raw[HW-1:0]};
        sgn    = merged[HW-1];
      end
      default: begin
        merged = {{(W-WD){1'b0}}, dst_in[WD-1:BY], raw[BY-1:0]};
        sgn    = merged[BY-1];
      end
    endcase
  end

  assign zer = (merged == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst_out   <= '0;
      flag_zero <= 1'b0;
      flag_neg  <= 1'b0;
      flag_pos  <= 1'b0;
      flag_ovf  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_out   <= merged;
        flag_zero <= zer;
        flag_neg  <= sgn;
        flag_pos  <= !zer && !sgn;
        flag_ovf  <= 1'b0;
      end
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(dst_out) && $stable(flag_zero)
                   && $stable(flag_neg) && $stable(flag_pos)));
  a_r6_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_zero == (dst_out == '0)));
  a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({flag_zero, flag_neg, flag_pos}) == 1 && !flag_ovf));
  a_r2_r3_r4_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt) != 3'd2) |-> (dst_out[W-1:WD] == '0));
endmodule

// File: tb/sim_logic_merge_unit.sv
`timescale 1ns/1ps
module sim_logic_merge_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = '0;
  logic [2:0]  fmt = '0;
  logic [63:0] dst_in = '0, src_in = '0;
  logic        out_valid, flag_zero, flag_neg, flag_pos, flag_ovf;
  logic [63:0] dst_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  logic_merge_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .fmt(fmt), .dst_in(dst_in), .src_in(src_in), .out_valid(out_valid), .dst_out(dst_out),
    .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_pos(flag_pos), .flag_ovf(flag_ovf));

  function automatic logic [63:0] m_val(logic [1:0] o, logic [2:0] f, logic [63:0] d, logic [63:0] s);
    logic [63:0] r;
    r = (o == 2'b00) ? (d & s) : (o == 2'b01) ? (d | s) : (d ^ s);
    if (f == 3'd2) return r;
    if (f == 3'd0) return {32'h0, r[31:0]};
    if (f == 3'd1 || f == 3'd3) return {32'h0, d[31:16], r[15:0]};
    return {32'h0, d[31:8], r[7:0]};
  endfunction

  function automatic logic m_neg(logic [2:0] f, logic [63:0] v);
    if (f == 3'd2) return v[63];
    if (f == 3'd0) return v[31];
    if (f == 3'd1 || f == 3'd3) return v[15];
    return v[7];
  endfunction

  function automatic string tag(logic [2:0] f);
    if (f == 3'd2) return "R5";
    if (f == 3'd0) return "R4";
    if (f == 3'd1 || f == 3'd3) return "R3";
    return "R2";
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(logic [1:0] o, logic [2:0] f, logic [63:0] d, logic [63:0] s, string req);
    logic [63:0] ev;
    logic en, ez;
    @(negedge clk);
    in_valid = 1'b1; op_sel = o; fmt = f; dst_in = d; src_in = s;
    ev = m_val(o, f, d, s);
    ez = (ev == 64'h0);
    en = m_neg(f, ev);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R9", {63'h0, out_valid}, 64'h1);
    chk(dst_out == ev, req, dst_out, ev);
    chk(flag_zero == ez, "R6", {63'h0, flag_zero}, {63'h0, ez});
    chk(flag_neg == en, "R7", {63'h0, flag_neg}, {63'h0, en});
    chk(flag_pos == (!ez && !en) && flag_ovf == 1'b0, "R8",
        {62'h0, flag_pos, flag_ovf}, {62'h0, (!ez && !en), 1'b0});
  endtask

  task automatic idle_check();
    logic [63:0] hv;
    logic [2:0] hf;
    hv = dst_out;
    hf = {flag_zero, flag_neg, flag_pos};
    @(negedge clk);
    in_valid = 1'b0; op_sel = 2'b10; fmt = 3'd2; dst_in = ~hv; src_in = 64'h1;
    @(negedge clk);
    chk(out_valid == 1'b0 && dst_out == hv && {flag_zero, flag_neg, flag_pos} == hf,
        "R10", dst_out, hv);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd, rs;
    logic [1:0] ro;
    logic [2:0] rf;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && dst_out == 0 && {flag_zero, flag_neg, flag_pos, flag_ovf} == 0,
        "R11", dst_out, 64'h0);
    rst_n = 1'b1;
    run(2'b00, 3'd0, 64'hFFFF_FFFF_1234_5678, 64'h0F0F_0F0F_F0F0_F0F0, "R1 R4 and word");
    run(2'b10, 3'd5, 64'hAAAA_AAAA_1122_3344, 64'h0000_0000_0000_00C4, "R2 xor byte");
    run(2'b01, 3'd3, 64'hFFFF_0000_ABCD_0001, 64'h0000_0000_0000_8000, "R3 or half");
    run(2'b00, 3'd2, 64'hF0F0_F0F0_F0F0_F0F0, 64'h0F0F_0F0F_0F0F_0F0F, "R5 and dword zero");
    run(2'b10, 3'd2, 64'h0, 64'h8000_0000_0000_0001, "R5 xor dword neg");
    run(2'b10, 3'd4, 64'h0000_0000_1200_00FF, 64'h0000_0000_0000_00FF, "R2 byte zero field");
    run(2'b11, 3'd1, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_FFFF, "R1 reserved op xor");
    run(2'b01, 3'd0, 64'h0, 64'h0000_0000_8000_0000, "R4 word neg");
    idle_check();
    for (int i = 0; i < 400; i++) begin
      rd = {$urandom, $urandom};
      rs = {$urandom, $urandom};
      ro = 2'($urandom);
      rf = 3'($urandom);
      run(ro, rf, rd, rs, tag(rf));
      if (i % 37 == 0) idle_check();
    end
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 0 && dst_out == 0, "R11", dst_out, 64'h0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule